// File: doc/BRIEF.md
# Cross-Clock Control Register Updater

This block keeps two control registers for a converter that is clocked from a slow clock, while a CPU on a fast clock writes them. A CPU write to either register is captured in a CPU-side holding register. A toggle request then carries it across to the converter clock, and the converter side loads the value into the selected register. The converter side returns an acknowledge toggle, and the CPU side sees that toggle through a second two-flop synchronizer.

One busy flag covers both registers. From the cycle a write is accepted until the acknowledge has come back, every further CPU write to either register is dropped without notice. The CPU reads the busy flag at bit 5 of the first register's readback value. That bit cannot be written: a 1 written there is stored as 0.

The CPU-side controller has two states:
- `CPU_IDLE` (not busy). A write in this state takes the transition *accept* to `CPU_WAIT_ACK`. The accept captures the data and the register select, updates the CPU-side readback copy and flips the request toggle.
- `CPU_WAIT_ACK` (busy). Writes in this state are dropped. The transition *ack_return* goes back to `CPU_IDLE` once the synchronized acknowledge toggle equals the request toggle.

Each clock domain has its own active-low reset, applied asynchronously and released synchronously.

Top module: `ccx_ctrl_updater`

## Requirements
- R1: After reset, both converter-side registers, both CPU readback values and the busy flag are all zero.
- R2: A write while not busy is accepted, and busy reads 1 in the CPU cycle after the accepting edge.
- R3: A write with select 0 (register A) reaches the converter-side register A before busy clears, and leaves register B unchanged.
- R4: A write with select 1 (register B) reaches the converter-side register B before busy clears, and leaves register A unchanged.
- R5: A write to the same register while busy is dropped: no converter register and no readback value changes because of it.
- R6: A pending update of one register also blocks writes to the other register.
- R7: Bit 5 of the register A readback is the busy flag. A value written to bit 5 of register A is stored as 0 on both sides.
- R8: Busy clears within 24 CPU cycles of the accept when the converter clock is no slower than a third of the CPU clock. The held data stays stable throughout the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-side clock |
| cpu_rst_n | input | 1 | CPU-side asynchronous reset, active low |
| cnv_clk | input | 1 | Converter-side clock |
| cnv_rst_n | input | 1 | Converter-side asynchronous reset, active low |
| cpu_wr_en | input | 1 | Write strobe, one CPU cycle |
| cpu_wr_sel | input | 1 | Register select: 0 for A, 1 for B |
| cpu_wr_data | input | 8 | Write data |
| cpu_busy | output | 1 | A transfer is in flight |
| cpu_rd_a | output | 8 | Register A readback, with busy at bit 5 |
| cpu_rd_b | output | 8 | Register B readback |
| cnv_reg_a | output | 8 | Register A in the converter domain |
| cnv_reg_b | output | 8 | Register B in the converter domain |

## Verification
The bench sweeps data values over both registers. A design that updated the wrong register, or let the second register's value bleed into the first, would show a mismatch on the untouched converter output. Writes issued straight after an accept, to the same register and to the other one, must leave no trace. A design that gated each register with its own busy flag would let the cross-register write through. The bench also writes 1 to bit 5 of register A and counts the cycles until busy clears. A design that stored bit 5, or that released busy before the acknowledge returned, would show a converter value that lags the readback or a busy window that is out of range.

// File: rtl/ccx_pkg.sv
package ccx_pkg;
    typedef enum logic [0:0] {
        CPU_IDLE     = 1'b0,
        CPU_WAIT_ACK = 1'b1
    } cpu_state_t;
endpackage

// File: rtl/ccx_rst_sync.sv
module ccx_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/ccx_bit_sync.sv
module ccx_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ccx_cpu_port.sv
module ccx_cpu_port
    import ccx_pkg::*;
#(
    parameter int DW       = 8,
    parameter int BUSY_BIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          ack_tog_s,
    output logic          req_tog,
    output logic [DW-1:0] hold_data,
    output logic          hold_sel,
    output logic          busy,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b
);
    localparam logic [DW-1:0] BUSY_MASK = DW'(1) << BUSY_BIT;

    cpu_state_t    state, state_nx;
    logic          accept;
    logic [DW-1:0] wdata_m;
    logic [DW-1:0] shadow_a, shadow_b;

    assign accept  = wr_en && (state == CPU_IDLE);
    assign wdata_m = wr_sel ? wr_data : (wr_data & ~BUSY_MASK);

    always_comb begin
        state_nx = state;
        unique case (state)
            CPU_IDLE:     if (accept) state_nx = CPU_WAIT_ACK;
            CPU_WAIT_ACK: if (ack_tog_s == req_tog) state_nx = CPU_IDLE;
            default:      state_nx = CPU_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= CPU_IDLE;
            req_tog   <= 1'b0;
            hold_data <= '0;
            hold_sel  <= 1'b0;
            shadow_a  <= '0;
            shadow_b  <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                req_tog   <= ~req_tog;
                hold_data <= wdata_m;
                hold_sel  <= wr_sel;
                if (wr_sel) shadow_b <= wdata_m;
                else        shadow_a <= wdata_m;
            end
        end
    end

    always_comb begin
        busy = (state == CPU_WAIT_ACK);
        rd_a = shadow_a | (busy ? BUSY_MASK : '0);
        rd_b = shadow_b;
    end

    assert_busy_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy) |=> busy);

    assert_drop_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> ($stable(shadow_a) && $stable(shadow_b) && $stable(req_tog)));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(hold_data) && $stable(hold_sel)));

    assert_busy_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a[BUSY_BIT] == busy);
endmodule

// File: rtl/ccx_cnv_port.sv
module ccx_cnv_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_tog_s,
    input  logic [DW-1:0] hold_data,
    input  logic          hold_sel,
    output logic          ack_tog,
    output logic [DW-1:0] reg_a,
    output logic [DW-1:0] reg_b
);
    logic seen;
    logic load;

    assign load    = (req_tog_s != seen);
    assign ack_tog = seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen  <= 1'b0;
            reg_a <= '0;
            reg_b <= '0;
        end else if (load) begin
            seen <= req_tog_s;
            if (hold_sel) reg_b <= hold_data;
            else          reg_a <= hold_data;
        end
    end

    assert_one_reg_per_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(reg_a) && !$stable(reg_b)));

    assert_update_only_on_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(reg_a) || !$stable(reg_b)) |-> $past(load));
endmodule

// File: rtl/ccx_ctrl_updater.sv
module ccx_ctrl_updater #(
    parameter int DW       = 8,
    parameter int BUSY_BIT = 5,
    parameter int SYNC_STG = 2
) (
    input  logic          cpu_clk,
    input  logic          cpu_rst_n,
    input  logic          cnv_clk,
    input  logic          cnv_rst_n,
    input  logic          cpu_wr_en,
    input  logic          cpu_wr_sel,
    input  logic [DW-1:0] cpu_wr_data,
    output logic          cpu_busy,
    output logic [DW-1:0] cpu_rd_a,
    output logic [DW-1:0] cpu_rd_b,
    output logic [DW-1:0] cnv_reg_a,
    output logic [DW-1:0] cnv_reg_b
);
    logic          cpu_rn, cnv_rn;
    logic          req_tog, req_tog_s, ack_tog, ack_tog_s;
    logic [DW-1:0] hold_data;
    logic          hold_sel;

    ccx_rst_sync #(.STAGES(SYNC_STG)) u_rst_cpu (.clk(cpu_clk), .arst_n(cpu_rst_n), .rst_n(cpu_rn));
    ccx_rst_sync #(.STAGES(SYNC_STG)) u_rst_cnv (.clk(cnv_clk), .arst_n(cnv_rst_n), .rst_n(cnv_rn));

    ccx_bit_sync #(.STAGES(SYNC_STG)) u_req_sync (.clk(cnv_clk), .rst_n(cnv_rn), .d(req_tog), .q(req_tog_s));
    ccx_bit_sync #(.STAGES(SYNC_STG)) u_ack_sync (.clk(cpu_clk), .rst_n(cpu_rn), .d(ack_tog), .q(ack_tog_s));

    ccx_cpu_port #(.DW(DW), .BUSY_BIT(BUSY_BIT)) u_cpu (
        .clk(cpu_clk), .rst_n(cpu_rn),
        .wr_en(cpu_wr_en), .wr_sel(cpu_wr_sel), .wr_data(cpu_wr_data),
        .ack_tog_s(ack_tog_s), .req_tog(req_tog),
        .hold_data(hold_data), .hold_sel(hold_sel),
        .busy(cpu_busy), .rd_a(cpu_rd_a), .rd_b(cpu_rd_b)
    );

    ccx_cnv_port #(.DW(DW)) u_cnv (
        .clk(cnv_clk), .rst_n(cnv_rn),
        .req_tog_s(req_tog_s), .hold_data(hold_data), .hold_sel(hold_sel),
        .ack_tog(ack_tog), .reg_a(cnv_reg_a), .reg_b(cnv_reg_b)
    );
endmodule

// File: tb/tb_ccx_ctrl_updater.sv
`timescale 1ns/1ps
module tb_ccx_ctrl_updater;
    logic       cpu_clk = 0, cnv_clk = 0;
    logic       cpu_rst_n = 0, cnv_rst_n = 0;
    logic       cpu_wr_en = 0, cpu_wr_sel = 0;
    logic [7:0] cpu_wr_data = 0;
    logic       cpu_busy;
    logic [7:0] cpu_rd_a, cpu_rd_b, cnv_reg_a, cnv_reg_b;

    int tests = 0, fails = 0, cyc = 0;
    logic [7:0] exp_a = 0, exp_b = 0;

    always #2 cpu_clk = ~cpu_clk;   // 250 MHz
    always #7 cnv_clk = ~cnv_clk;   // converter clock, slower and unrelated
    always @(posedge cpu_clk) cyc++;

    ccx_ctrl_updater dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle(input string req, output int n);
        n = 0;
        while (cpu_busy && n < 60) begin @(negedge cpu_clk); n++; end
    endtask

    // one accepted write plus optional dropped writes while busy
    task automatic do_write(input logic sel, input logic [7:0] d, input int extra);
        int n;
        logic [7:0] stored;
        @(negedge cpu_clk);
        cpu_wr_en = 1; cpu_wr_sel = sel; cpu_wr_data = d;
        @(negedge cpu_clk);
        cpu_wr_en = 0;
        chk("R2 busy after accept", cpu_busy, 1);
        chk("R7 busy at bit5", cpu_rd_a[5], 1);
        stored = sel ? d : (d & 8'hDF);
        if (sel) exp_b = stored; else exp_a = stored;
        if (extra > 0) begin
            cpu_wr_en = 1; cpu_wr_sel = sel; cpu_wr_data = ~d;   // R5
            @(negedge cpu_clk);
            cpu_wr_en = 1; cpu_wr_sel = ~sel; cpu_wr_data = d ^ 8'h5A; // R6
            @(negedge cpu_clk);
            cpu_wr_en = 0;
        end
        wait_idle("R8", n);
        chk("R8 busy clears within bound", (n + extra*2 <= 24), 1);
        chk(sel ? "R4 reg B" : "R3 reg A", sel ? cnv_reg_b : cnv_reg_a, stored);
        chk(sel ? "R4 reg A untouched" : "R3 reg B untouched",
            sel ? cnv_reg_a : cnv_reg_b, sel ? exp_a : exp_b);
        if (extra > 0) begin
            repeat (30) @(negedge cpu_clk);
            chk("R5 same-reg write dropped", sel ? cnv_reg_b : cnv_reg_a, stored);
            chk("R6 other-reg write dropped", sel ? cnv_reg_a : cnv_reg_b, sel ? exp_a : exp_b);
            chk("R5 readback A", cpu_rd_a, exp_a);
            chk("R6 readback B", cpu_rd_b, exp_b);
        end
        chk("R7 converter A bit5 clear", cnv_reg_a[5], 0);
        chk("R7 readback A idle", cpu_rd_a, exp_a);
    endtask

    initial begin
        #1000;
        wait (cyc > 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #23 cpu_rst_n = 1;
        #9  cnv_rst_n = 1;
        repeat (6) @(negedge cpu_clk);
        chk("R1 busy reset", cpu_busy, 0);
        chk("R1 rd_a reset", cpu_rd_a, 0);
        chk("R1 rd_b reset", cpu_rd_b, 0);
        chk("R1 cnv_a reset", cnv_reg_a, 0);
        chk("R1 cnv_b reset", cnv_reg_b, 0);
        for (int v = 0; v < 256; v += 17) begin
            do_write(1'b0, 8'(v), 0);
            do_write(1'b1, 8'(255 - v), 0);
        end
        do_write(1'b0, 8'hFF, 0);   // R7: bit5 written as one
        do_write(1'b0, 8'h3C, 1);
        do_write(1'b1, 8'hA5, 1);
        do_write(1'b0, 8'h20, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule